// File: doc/BRIEF.md
# Charge-Balance Period Ratio Converter

This block is the digital timing and arithmetic core of a dual-slope, charge-balancing converter. An external integrator ramps until a comparator trips. The block then flips a reference-direction output so that the ramp reverses. Over a set number of whole ramp periods it counts the clock cycles spent ramping each way. It then reduces the two totals to one signed ratio, (Tp − Tm)/(Tp + Tm). The capacitor value and the trip threshold drop out of that ratio.

A start strobe arms a measurement. The comparator edge that follows the start only closes the ramp that was already under way, and that time is thrown away. After that edge, every cycle is charged to the positive or the negative total according to the current direction. Once `PERIODS` complete periods have been collected, a sequential restoring divider forms the quotient. The block then posts a 22-bit offset-binary code in a 24-bit word and pulses a done flag.

Top module: `chargeBalanceCore`

## Requirements
- R1: After reset `dirOut`, `done` and `result` are all zero.
- R2: Each rising edge of `cmpIn` toggles `dirOut`. The toggle is visible three clock edges after the input change: two for the synchronizer and one for the register. A falling edge of `cmpIn` has no effect on `dirOut`.
- R3: `start` forces `dirOut` to 0 at the next clock edge and arms a new measurement. The first rising comparator edge after `start` is not followed by any counting of the time before it.
- R4: After that discarded edge, each clock cycle up to and including the next edge is added to Tp while `dirOut` is 0 and to Tm while `dirOut` is 1. Each interval between two edges therefore contributes exactly its length in cycles. The first counted interval is a Tm interval. The measurement closes on the 2·`PERIODS`-th counted edge.
- R5: `result` equals 0x200000 + trunc((Tp − Tm)·2^21 / (Tp + Tm)), with truncation toward zero and bits 23:22 always zero. Equal totals give 0x200000.
- R6: Codes clip at 0x000000 and 0x3FFFFF. `done` is high for exactly one cycle, 27 clock edges after the `cmpIn` rise that closes the measurement, and `result` changes only at that edge.
- R7: A `start` in the middle of a measurement abandons it, and the next result reflects only the edges after the new `start`.
- R8: Comparator edges while no measurement is armed toggle `dirOut` but raise no `done` and leave `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that arms a new measurement |
| cmpIn | input | 1 | Asynchronous comparator level from the integrator |
| dirOut | output | 1 | Reference direction: 0 positive, 1 negative |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 24 | Offset-binary code, 22 significant bits |

## Verification
The direction toggle is due on the third clock edge after the comparator input rises. The bench samples `dirOut` at the falling edges after edges two and three so that it sees both the old and the new value. The result is due 27 edges after the closing comparator rise: 3 edges to detect it, 1 edge to load the divider, 22 divider steps and 1 edge to write the code. The bench counts falling edges from that rise and requires `done` first at count 27 and low again at count 28. Expected codes come from the interval table through the R5 formula. All stimulus is applied at falling edges, so the number of cycles in each interval is exact.

// File: rtl/cbcPkg.sv
package cbcPkg;
  localparam int RES_W = 22;
  localparam int OUT_W = 24;
  localparam int ITERS = RES_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SKIP, ST_ACC, ST_LOAD, ST_DIV, ST_FIN
  } ctrlState_e;

  typedef struct packed {
    logic clr;
    logic incPos;
    logic incNeg;
    logic load;
    logic step;
    logic first;
    logic finish;
  } strobes_t;
endpackage

// File: rtl/cbcSync.sv
module cbcSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] shReg;
  logic prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      prevLvl <= 1'b0;
    end else begin
      shReg   <= {shReg[STAGES-2:0], din};
      prevLvl <= shReg[STAGES-1];
    end
  end

  assign rise = shReg[STAGES-1] & ~prevLvl;
endmodule

// File: rtl/cbcCtrl.sv
module cbcCtrl
  import cbcPkg::*;
#(
  parameter int PERIODS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     rise,
  output logic     dirOut,
  output strobes_t strb
);
  localparam int EDGES = 2 * PERIODS;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int IW    = $clog2(ITERS);

  ctrlState_e    state;
  logic [EW-1:0] edgeCnt;
  logic [IW-1:0] itr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dirOut  <= 1'b0;
      edgeCnt <= '0;
      itr     <= '0;
    end else if (start) begin
      state   <= ST_SKIP;
      dirOut  <= 1'b0;
      edgeCnt <= '0;
    end else begin
      if (rise) dirOut <= ~dirOut;
      case (state)
        ST_SKIP: if (rise) state <= ST_ACC;
        ST_ACC: if (rise) begin
          if (edgeCnt == EW'(EDGES - 1)) state <= ST_LOAD;
          else edgeCnt <= edgeCnt + 1'b1;
        end
        ST_LOAD: begin
          state <= ST_DIV;
          itr   <= '0;
        end
        ST_DIV: begin
          itr <= itr + 1'b1;
          if (itr == IW'(ITERS - 1)) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb     = '0;
    strb.clr = start;
    if (!start) begin
      strb.incPos = (state == ST_ACC) && !dirOut;
      strb.incNeg = (state == ST_ACC) && dirOut;
      strb.load   = (state == ST_LOAD);
      strb.step   = (state == ST_DIV);
      strb.first  = (state == ST_DIV) && (itr == '0);
      strb.finish = (state == ST_FIN);
    end
  end

  // R2: a detected edge flips the direction on the next cycle
  a_r2_dir_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (rise && !start) |=> (dirOut != $past(dirOut)));
  // R3: start always leaves the direction positive
  a_r3_start_dir: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !dirOut);
  // R4: never charge both totals in one cycle
  a_r4_one_total: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.incPos, strb.incNeg}));
  // R6: the final write comes only after the divider ran
  a_r6_fin_after_div: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |-> $past(state == ST_DIV));
endmodule

// File: rtl/cbcDatapath.sv
module cbcDatapath
  import cbcPkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  output logic             done,
  output logic [OUT_W-1:0] result
);
  localparam int SW = CNT_W + 1;
  localparam int RW = SW + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [RES_W:0]   MID  = (RES_W + 1)'(1) << (RES_W - 1);
  localparam logic [RES_W:0]   FULL = ((RES_W + 1)'(1) << RES_W) - 1'b1;

  logic [CNT_W-1:0] tp, tm;
  logic [RW-1:0]    rem, trial, denExt;
  logic [SW-1:0]    den, sumW, diffW;
  logic             neg, zeroDen;
  logic [RES_W-1:0] quo;
  logic [RES_W:0]   magExt, codeW;

  always_comb begin
    sumW   = SW'(tp) + SW'(tm);
    diffW  = (tp >= tm) ? SW'(tp - tm) : SW'(tm - tp);
    denExt = RW'(den);
    trial  = strb.first ? rem : {rem[RW-2:0], 1'b0};
    magExt = {1'b0, quo};
    if (zeroDen)  codeW = FULL;
    else if (neg) codeW = (magExt > MID) ? '0 : MID - magExt;
    else          codeW = ((MID + magExt) > FULL) ? FULL : MID + magExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tp      <= '0;
      tm      <= '0;
      rem     <= '0;
      den     <= '0;
      neg     <= 1'b0;
      zeroDen <= 1'b0;
      quo     <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      if (strb.clr) begin
        tp <= '0;
        tm <= '0;
      end
      if (strb.incPos && tp != CNT_MAX) tp <= tp + 1'b1;
      if (strb.incNeg && tm != CNT_MAX) tm <= tm + 1'b1;
      if (strb.load) begin
        rem     <= RW'(diffW);
        den     <= sumW;
        neg     <= (tm > tp);
        zeroDen <= (sumW == '0);
        quo     <= '0;
      end
      if (strb.step) begin
        if (trial >= denExt) begin
          rem <= trial - denExt;
          quo <= {quo[RES_W-2:0], 1'b1};
        end else begin
          rem <= trial;
          quo <= {quo[RES_W-2:0], 1'b0};
        end
      end
      if (strb.finish) begin
        result <= {{(OUT_W - RES_W){1'b0}}, codeW[RES_W-1:0]};
        done   <= 1'b1;
      end
    end
  end

  // R5: the padding bits above the code stay clear
  a_r5_top_bits: assert property (@(posedge clk) disable iff (!rstN)
    result[OUT_W-1:RES_W] == '0);
  // R5: after each divider step the remainder is below the divisor
  a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && den != '0) |=> (rem < denExt));
  // R6: done never lasts two cycles
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: result only moves together with done
  a_r6_result_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));
endmodule

// File: rtl/chargeBalanceCore.sv
module chargeBalanceCore
  import cbcPkg::*;
#(
  parameter int PERIODS = 2,
  parameter int CNT_W   = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cmpIn,
  output logic             dirOut,
  output logic             done,
  output logic [OUT_W-1:0] result
);
  logic     rise;
  strobes_t strb;

  cbcSync #(.STAGES(2)) i_sync (
    .clk(clk), .rstN(rstN), .din(cmpIn), .rise(rise)
  );

  cbcCtrl #(.PERIODS(PERIODS)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rise(rise),
    .dirOut(dirOut), .strb(strb)
  );

  cbcDatapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .done(done), .result(result)
  );
endmodule

// File: tb/test_chargeBalanceCore.sv
module test_chargeBalanceCore;
  localparam int NV = 7;
  // intervals between counted edges: Tm, Tp, Tm, Tp
  localparam int VEC [NV][4] = '{
    '{10, 10, 10, 10},
    '{5, 15, 5, 15},
    '{15, 5, 15, 5},
    '{3, 200, 3, 200},
    '{200, 3, 200, 3},
    '{7, 3, 9, 4},
    '{3000, 2000, 1000, 5000}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, cmpIn = 1'b0;
  logic dirOut, done;
  logic [23:0] result;
  int checks = 0, errors = 0, doneCnt = 0;

  chargeBalanceCore i_chargeBalanceCore (
    .clk(clk), .rstN(rstN), .start(start), .cmpIn(cmpIn),
    .dirOut(dirOut), .done(done), .result(result)
  );

  always #2 clk = ~clk;
  always @(negedge clk) if (done) doneCnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int expCode(input int tp, input int tm);
    longint d, ad, s, mag, code;
    d = longint'(tp) - longint'(tm);
    s = longint'(tp) + longint'(tm);
    ad = (d < 0) ? -d : d;
    mag = (ad <<< 21) / s;
    code = (d < 0) ? (64'd2097152 - mag) : (64'd2097152 + mag);
    if (code > 4194303) code = 4194303;
    if (code < 0) code = 0;
    return int'(code);
  endfunction

  task automatic rise(input int n);
    cmpIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmpIn = 1'b0;
    repeat (n - 2) @(negedge clk);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runConv(input int a, input int b, input int c, input int e, output int code);
    int lat;
    lat = 0;
    pulseStart();
    rise(a);
    rise(b);
    rise(c);
    rise(e);
    cmpIn = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 2) cmpIn = 1'b0;
      if (done && lat == 0) begin
        lat = k;
        break;
      end
    end
    chk(lat == 27, "R6 latency", lat, 27);
    code = int'(result);
    @(negedge clk);
    chk(!done, "R6 one-cycle done", int'(done), 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int code, d0, r0, dc0;
    repeat (3) @(negedge clk);
    chk(dirOut == 1'b0, "R1 dirOut", int'(dirOut), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(result == 24'h0, "R1 result", int'(result), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: toggle latency and falling edge ignored
    d0 = int'(dirOut);
    cmpIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(int'(dirOut) == d0, "R2 before third edge", int'(dirOut), d0);
    @(negedge clk);
    chk(int'(dirOut) != d0, "R2 toggled", int'(dirOut), 1 - d0);
    cmpIn = 1'b0;
    repeat (6) @(negedge clk);
    chk(int'(dirOut) != d0, "R2 falling edge no effect", int'(dirOut), 1 - d0);

    // R3: start forces positive direction
    pulseStart();
    chk(dirOut == 1'b0, "R3 start clears dirOut", int'(dirOut), 0);
    repeat (3) @(negedge clk);

    // R4 R5: table of interval vectors
    for (int v = 0; v < NV; v++) begin
      runConv(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], code);
      chk(code == expCode(VEC[v][1] + VEC[v][3], VEC[v][0] + VEC[v][2]),
          "R4 R5 code", code, expCode(VEC[v][1] + VEC[v][3], VEC[v][0] + VEC[v][2]));
      repeat (4) @(negedge clk);
    end

    // R5: balanced totals give mid scale
    runConv(4, 9, 9, 4, code);
    chk(code == 32'h200000, "R5 mid scale", code, 32'h200000);
    chk(result[23:22] == 2'b00, "R5 top bits", int'(result[23:22]), 0);
    repeat (4) @(negedge clk);

    // R7: restart mid measurement
    pulseStart();
    rise(20);
    rise(3);
    rise(30);
    runConv(5, 15, 5, 15, code);
    chk(code == 32'h300000, "R7 restart", code, 32'h300000);
    repeat (4) @(negedge clk);

    // R8: idle edges leave result alone
    r0 = int'(result);
    dc0 = doneCnt;
    d0 = int'(dirOut);
    for (int i = 0; i < 5; i++) rise(5);
    repeat (40) @(negedge clk);
    chk(doneCnt == dc0, "R8 no done", doneCnt, dc0);
    chk(int'(result) == r0, "R8 result held", int'(result), r0);
    chk(int'(dirOut) != d0, "R8 dirOut toggled", int'(dirOut), 1 - d0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule